// File: doc/BRIEF.md
# Fail-First Vector Compare-Immediate Walker

This block steps a compare-against-immediate operation across a run of element registers, one element per clock. For every element it fetches a source value from a small internal register file, compares it as a signed number with a sign-extended immediate, and produces a three-bit one-hot condition field. The field is then tested against one chosen bit with a chosen sense. While the test passes, the field is stored into a condition array and the walk goes on. On the first element whose test fails, the walk stops and the vector length is cut short.

Two truncation flavours exist. Inclusive keeps the failing element: it is stored and counted in the new length. Exclusive drops it: the field is not stored and the new length ends just before it, which can be zero. Because elements are evaluated strictly in order and a field is only written once its own test has been decided, no result past the new length is ever committed. The source and the destination can each be vector-stepped, moving one register per element, or scalar, reusing one register for every element.

The host preloads source registers through a write port, starts a walk with a one-cycle pulse that latches the whole configuration, waits for `done`, and reads back the condition array through a combinational read port.

Top module: `ffc_walker`

## Requirements
- R1: After an accepted start with a nonzero length, `busy` is high for exactly one cycle per evaluated element (element 0 first, then 1, 2, ... in order) and then drops in the same cycle that `done` rises; `busy` and `done` are never high together.
- R2: The source register index starts at the configured base and increases by one per element, modulo NREG, when the source is vector-stepped; when it is scalar the same register is read for every element.
- R3: The destination condition index starts at its base and increases by one per element, modulo NCR, when vector-stepped; when scalar every written field goes to the same entry, the last write remaining.
- R4: The condition field is bit 2 = source less than immediate, bit 1 = greater than, bit 0 = equal, comparing both as signed two's-complement with the immediate sign-extended; exactly one bit is set in every stored field.
- R5: The test selector picks bit 2 for code 0, bit 1 for code 1, and bit 0 for codes 2 and 3; with sense 1 an element passes when the picked bit is 1, with sense 0 when it is 0.
- R6: In inclusive mode, a failing element at index i is stored, `vl_out` becomes i+1, `truncated` is 1, and no later element is evaluated or stored.
- R7: In exclusive mode, a failing element at index i is not stored, `vl_out` becomes i (0 when i is 0), `truncated` is 1, and no later element is stored.
- R8: When every element passes, `vl_out` equals the configured length and `truncated` is 0.
- R9: A start with length 0 raises `done` at the next edge with `vl_out` 0, `truncated` 0, no `busy` cycle and no condition write.
- R10: After reset, `busy`, `done`, `truncated` and `vl_out` are 0 and every condition entry reads 0.
- R11: The configuration is captured at the start edge; a `start` pulse or configuration change while `busy` is high has no effect on the running walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a walk when idle |
| cfg_vl | input | VLW | Requested vector length |
| cfg_src_base | input | RAW | First source register index |
| cfg_src_vec | input | 1 | 1: source steps per element, 0: scalar |
| cfg_dst_base | input | CAW | First condition entry index |
| cfg_dst_vec | input | 1 | 1: destination steps per element, 0: scalar |
| cfg_imm | input | IMMW | Signed immediate |
| cfg_sel | input | 2 | Condition bit selector |
| cfg_sense | input | 1 | 1: pass when selected bit set, 0: pass when clear |
| cfg_excl | input | 1 | 1: exclusive truncation, 0: inclusive |
| gpr_we | input | 1 | Source register write enable |
| gpr_waddr | input | RAW | Source register write index |
| gpr_wdata | input | XLEN | Source register write data |
| cr_raddr | input | CAW | Condition entry read index |
| cr_rdata | output | 3 | Condition entry read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished; held until the next accepted start |
| vl_out | output | VLW | Resulting vector length |
| truncated | output | 1 | A failing element ended the walk |

## Verification
On every cycle the assertions watch the element index stepping by one, the source and destination indices stepping or holding according to their vector flags, one-hot content of every stored field, the absence of any store for an exclusive failure or while idle, and the bound of the result length against the latched length. Which element fails, the exact resulting length in each mode, the final contents of the condition array, index wrap-around, the zero-length start and the ignored start pulse mid-walk can only be shown by the bench's scenarios against its own model of the walk.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ffc_state_e;

    // bit positions inside a condition field
    localparam int unsigned CF_LT = 2;
    localparam int unsigned CF_GT = 1;
    localparam int unsigned CF_EQ = 0;
    localparam int unsigned CF_W  = 3;

    // selector codes
    localparam logic [1:0] SEL_LT = 2'd0;
    localparam logic [1:0] SEL_GT = 2'd1;

endpackage

// File: rtl/ffc_regfile.sv
module ffc_regfile #(
    parameter int unsigned XLEN = 16,
    parameter int unsigned NREG = 16,
    parameter int unsigned NCR  = 8,
    localparam int unsigned RAW = $clog2(NREG),
    localparam int unsigned CAW = $clog2(NCR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gpr_we,
    input  logic [RAW-1:0]       gpr_waddr,
    input  logic [XLEN-1:0]      gpr_wdata,
    input  logic [RAW-1:0]       gpr_raddr,
    output logic [XLEN-1:0]      gpr_rdata,
    input  logic                 cr_we,
    input  logic [CAW-1:0]       cr_waddr,
    input  logic [ffc_pkg::CF_W-1:0] cr_wdata,
    input  logic [CAW-1:0]       cr_raddr,
    output logic [ffc_pkg::CF_W-1:0] cr_rdata
);
    logic [XLEN-1:0]          gpr_q [NREG];
    logic [ffc_pkg::CF_W-1:0] cr_q  [NCR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) gpr_q[k] <= '0;
        end else if (gpr_we) begin
            gpr_q[gpr_waddr] <= gpr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCR; k++) cr_q[k] <= '0;
        end else if (cr_we) begin
            cr_q[cr_waddr] <= cr_wdata;
        end
    end

    assign gpr_rdata = gpr_q[gpr_raddr];
    assign cr_rdata  = cr_q[cr_raddr];
endmodule

// File: rtl/ffc_eval.sv
module ffc_eval #(
    parameter int unsigned XLEN = 16,
    parameter int unsigned IMMW = 8
) (
    input  logic [XLEN-1:0]          src_val,
    input  logic [IMMW-1:0]          imm,
    input  logic [1:0]               sel,
    input  logic                     sense,
    output logic [ffc_pkg::CF_W-1:0] cfield,
    output logic                     pass
);
    import ffc_pkg::*;

    logic [XLEN-1:0] imm_ext;
    logic            pick;

    generate
        if (XLEN > IMMW) begin : g_ext
            assign imm_ext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        cfield        = '0;
        cfield[CF_LT] = $signed(src_val) <  $signed(imm_ext);
        cfield[CF_GT] = $signed(src_val) >  $signed(imm_ext);
        cfield[CF_EQ] = src_val == imm_ext;
        case (sel)
            SEL_LT:  pick = cfield[CF_LT];
            SEL_GT:  pick = cfield[CF_GT];
            default: pick = cfield[CF_EQ];
        endcase
        pass = sense ? pick : !pick;
    end
endmodule

// File: rtl/ffc_walker.sv
module ffc_walker #(
    parameter int unsigned XLEN = 16,
    parameter int unsigned NREG = 16,
    parameter int unsigned NCR  = 8,
    parameter int unsigned IMMW = 8,
    parameter int unsigned VLW  = 5,
    localparam int unsigned RAW = $clog2(NREG),
    localparam int unsigned CAW = $clog2(NCR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   cfg_vl,
    input  logic [RAW-1:0]   cfg_src_base,
    input  logic             cfg_src_vec,
    input  logic [CAW-1:0]   cfg_dst_base,
    input  logic             cfg_dst_vec,
    input  logic [IMMW-1:0]  cfg_imm,
    input  logic [1:0]       cfg_sel,
    input  logic             cfg_sense,
    input  logic             cfg_excl,
    input  logic             gpr_we,
    input  logic [RAW-1:0]   gpr_waddr,
    input  logic [XLEN-1:0]  gpr_wdata,
    input  logic [CAW-1:0]   cr_raddr,
    output logic [2:0]       cr_rdata,
    output logic             busy,
    output logic             done,
    output logic [VLW-1:0]   vl_out,
    output logic             truncated
);
    import ffc_pkg::*;

    typedef struct packed {
        ffc_state_e     state;
        logic [VLW-1:0] idx;
        logic [VLW-1:0] vl;
        logic [RAW-1:0] src_ptr;
        logic [CAW-1:0] dst_ptr;
        logic           src_vec;
        logic           dst_vec;
        logic [IMMW-1:0] imm;
        logic [1:0]     sel;
        logic           sense;
        logic           excl;
        logic           done;
        logic [VLW-1:0] vl_res;
        logic           trunc;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [XLEN-1:0]  src_val;
    logic [CF_W-1:0]  cfield;
    logic             elem_pass;
    logic             cr_we;

    // observation signals for the bound checker
    logic [VLW-1:0]   obs_idx;
    logic [VLW-1:0]   obs_vl;
    logic [RAW-1:0]   obs_src_ptr;
    logic [CAW-1:0]   obs_dst_ptr;
    logic             obs_src_vec;
    logic             obs_dst_vec;
    logic             obs_excl;

    ffc_regfile #(
        .XLEN (XLEN),
        .NREG (NREG),
        .NCR  (NCR)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpr_we    (gpr_we),
        .gpr_waddr (gpr_waddr),
        .gpr_wdata (gpr_wdata),
        .gpr_raddr (walk_q.src_ptr),
        .gpr_rdata (src_val),
        .cr_we     (cr_we),
        .cr_waddr  (walk_q.dst_ptr),
        .cr_wdata  (cfield),
        .cr_raddr  (cr_raddr),
        .cr_rdata  (cr_rdata)
    );

    ffc_eval #(
        .XLEN (XLEN),
        .IMMW (IMMW)
    ) u_eval (
        .src_val (src_val),
        .imm     (walk_q.imm),
        .sel     (walk_q.sel),
        .sense   (walk_q.sense),
        .cfield  (cfield),
        .pass    (elem_pass)
    );

    always_comb begin
        walk_d = walk_q;
        cr_we  = 1'b0;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (start) begin
                    walk_d.idx     = '0;
                    walk_d.vl      = cfg_vl;
                    walk_d.src_ptr = cfg_src_base;
                    walk_d.dst_ptr = cfg_dst_base;
                    walk_d.src_vec = cfg_src_vec;
                    walk_d.dst_vec = cfg_dst_vec;
                    walk_d.imm     = cfg_imm;
                    walk_d.sel     = cfg_sel;
                    walk_d.sense   = cfg_sense;
                    walk_d.excl    = cfg_excl;
                    walk_d.trunc   = 1'b0;
                    walk_d.vl_res  = '0;
                    if (cfg_vl == '0) begin
                        walk_d.done  = 1'b1;
                    end else begin
                        walk_d.done  = 1'b0;
                        walk_d.state = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (elem_pass) begin
                    cr_we = 1'b1;
                    if (walk_q.idx == walk_q.vl - 1'b1) begin
                        walk_d.state  = ST_IDLE;
                        walk_d.done   = 1'b1;
                        walk_d.vl_res = walk_q.vl;
                    end else begin
                        walk_d.idx = walk_q.idx + 1'b1;
                        if (walk_q.src_vec) walk_d.src_ptr = walk_q.src_ptr + 1'b1;
                        if (walk_q.dst_vec) walk_d.dst_ptr = walk_q.dst_ptr + 1'b1;
                    end
                end else begin
                    cr_we         = !walk_q.excl;
                    walk_d.state  = ST_IDLE;
                    walk_d.done   = 1'b1;
                    walk_d.trunc  = 1'b1;
                    walk_d.vl_res = walk_q.excl ? walk_q.idx : walk_q.idx + 1'b1;
                end
            end
            default: walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy      = walk_q.state == ST_RUN;
    assign done      = walk_q.done;
    assign vl_out    = walk_q.vl_res;
    assign truncated = walk_q.trunc;

    assign obs_idx     = walk_q.idx;
    assign obs_vl      = walk_q.vl;
    assign obs_src_ptr = walk_q.src_ptr;
    assign obs_dst_ptr = walk_q.dst_ptr;
    assign obs_src_vec = walk_q.src_vec;
    assign obs_dst_vec = walk_q.dst_vec;
    assign obs_excl    = walk_q.excl;
endmodule

// File: rtl/ffc_walker_chk.sv
module ffc_walker_chk #(
    parameter int unsigned VLW = 5,
    parameter int unsigned RAW = 4,
    parameter int unsigned CAW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic [VLW-1:0] vl_out,
    input logic           truncated,
    input logic           cr_we,
    input logic [2:0]     cfield,
    input logic           elem_pass,
    input logic [VLW-1:0] obs_idx,
    input logic [VLW-1:0] obs_vl,
    input logic [RAW-1:0] obs_src_ptr,
    input logic [CAW-1:0] obs_dst_ptr,
    input logic           obs_src_vec,
    input logic           obs_dst_vec,
    input logic           obs_excl
);
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R1
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> obs_idx == VLW'($past(obs_idx) + 1'b1)); // R1
    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && obs_src_vec) |-> obs_src_ptr == RAW'($past(obs_src_ptr) + 1'b1)); // R2
    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !obs_src_vec) |-> $stable(obs_src_ptr)); // R2
    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && obs_dst_vec) |-> obs_dst_ptr == CAW'($past(obs_dst_ptr) + 1'b1)); // R3
    AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !obs_dst_vec) |-> $stable(obs_dst_ptr)); // R3
    AST_FIELD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> $countones(cfield) == 1); // R4
    AST_EXCL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && !elem_pass) |-> !obs_excl); // R7
    AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> vl_out <= obs_vl); // R6
    AST_FULL_VL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !truncated) |-> vl_out == obs_vl); // R8
    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cr_we); // R9
endmodule

bind ffc_walker ffc_walker_chk #(
    .VLW (VLW),
    .RAW (RAW),
    .CAW (CAW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .vl_out      (vl_out),
    .truncated   (truncated),
    .cr_we       (cr_we),
    .cfield      (cfield),
    .elem_pass   (elem_pass),
    .obs_idx     (obs_idx),
    .obs_vl      (obs_vl),
    .obs_src_ptr (obs_src_ptr),
    .obs_dst_ptr (obs_dst_ptr),
    .obs_src_vec (obs_src_vec),
    .obs_dst_vec (obs_dst_vec),
    .obs_excl    (obs_excl)
);

// File: tb/ffc_walker_bench.sv
`timescale 1ns/100ps
module ffc_walker_bench;
    localparam int XLEN = 16;
    localparam int NREG = 16;
    localparam int NCR  = 8;
    localparam int IMMW = 8;
    localparam int VLW  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VLW-1:0]   cfg_vl = '0;
    logic [3:0]       cfg_src_base = '0;
    logic             cfg_src_vec = 1'b0;
    logic [2:0]       cfg_dst_base = '0;
    logic             cfg_dst_vec = 1'b0;
    logic [IMMW-1:0]  cfg_imm = '0;
    logic [1:0]       cfg_sel = '0;
    logic             cfg_sense = 1'b0;
    logic             cfg_excl = 1'b0;
    logic             gpr_we = 1'b0;
    logic [3:0]       gpr_waddr = '0;
    logic [XLEN-1:0]  gpr_wdata = '0;
    logic [2:0]       cr_raddr = '0;
    logic [2:0]       cr_rdata;
    logic             busy, done, truncated;
    logic [VLW-1:0]   vl_out;

    int total = 0;
    int bad   = 0;

    // reference state
    int gpr_m [NREG];
    int cr_m  [NCR];

    always #2.5 clk = ~clk;

    ffc_walker u_ffc_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_vl(cfg_vl),
        .cfg_src_base(cfg_src_base), .cfg_src_vec(cfg_src_vec),
        .cfg_dst_base(cfg_dst_base), .cfg_dst_vec(cfg_dst_vec),
        .cfg_imm(cfg_imm), .cfg_sel(cfg_sel), .cfg_sense(cfg_sense),
        .cfg_excl(cfg_excl), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
        .gpr_wdata(gpr_wdata), .cr_raddr(cr_raddr), .cr_rdata(cr_rdata),
        .busy(busy), .done(done), .vl_out(vl_out), .truncated(truncated)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load_gpr(input int a, input int v);
        @(negedge clk);
        gpr_we = 1'b1; gpr_waddr = 4'(a); gpr_wdata = XLEN'(v);
        @(negedge clk);
        gpr_we = 1'b0;
        gpr_m[a] = int'($signed(XLEN'(v)));
    endtask

    task automatic check_cr_file(input string req);
        for (int a = 0; a < NCR; a++) begin
            cr_raddr = 3'(a);
            #0.5;
            check(req, int'(cr_rdata), cr_m[a]);
        end
    endtask

    // R4 field, R5 test
    function automatic int field_of(input int s, input int imm);
        if (s < imm) return 4;
        if (s > imm) return 2;
        return 1;
    endfunction

    function automatic bit passes(input int f, input int sel, input int sense);
        int b;
        b = (sel == 0) ? 4 : (sel == 1) ? 2 : 1;
        return sense ? ((f & b) != 0) : ((f & b) == 0);
    endfunction

    task automatic run(input string name, input int vl, input int sb, input int sv,
                       input int db, input int dv, input int imm, input int sel,
                       input int sense, input int excl, input bit inject);
        int steps, exp_vl, exp_tr, immv;
        steps = vl; exp_vl = vl; exp_tr = 0;
        immv = int'($signed(IMMW'(imm)));
        for (int i = 0; i < vl; i++) begin
            int s, f, d;
            s = gpr_m[(sb + (sv ? i : 0)) % NREG];
            d = (db + (dv ? i : 0)) % NCR;
            f = field_of(s, immv);
            if (passes(f, sel, sense)) begin
                cr_m[d] = f;
            end else begin
                if (!excl) cr_m[d] = f;
                exp_vl = excl ? i : i + 1;
                exp_tr = 1;
                steps  = i + 1;
                break;
            end
        end
        if (vl == 0) steps = 0;

        @(negedge clk);
        start = 1'b1; cfg_vl = VLW'(vl); cfg_src_base = 4'(sb); cfg_src_vec = sv[0];
        cfg_dst_base = 3'(db); cfg_dst_vec = dv[0]; cfg_imm = IMMW'(imm);
        cfg_sel = 2'(sel); cfg_sense = sense[0]; cfg_excl = excl[0];
        for (int j = 0; j <= steps; j++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && j == 1) begin
                // R11: a pulse with a different configuration mid-walk
                start = 1'b1; cfg_vl = '0; cfg_src_base = 4'(sb + 3);
                cfg_excl = ~excl[0]; cfg_imm = ~IMMW'(imm);
            end
            check({name, " R1 busy"}, int'(busy), (j < steps) ? 1 : 0);
            if (j == steps) begin
                check({name, " R1 done"}, int'(done), 1);
                check({name, " R6 R7 R8 R9 vl_out"}, int'(vl_out), exp_vl);
                check({name, " R6 R7 R8 truncated"}, int'(truncated), exp_tr);
            end
        end
        start = 1'b0;
        // extra idle cycle: R11 pulse must not have restarted anything
        @(negedge clk);
        check({name, " R11 stays idle"}, int'(busy), 0);
        check({name, " R11 result held"}, int'(vl_out), exp_vl);
        check_cr_file({name, " R2 R3 R4 R5 cr contents"});
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int vals [16] = '{5, -3, 0, 12, 7, -100, 3, 2, 9, 0, -1, 4, 100, -50, 6, 1};
        for (int k = 0; k < NREG; k++) gpr_m[k] = 0;
        for (int k = 0; k < NCR; k++) cr_m[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 vl_out", int'(vl_out), 0);
        check("R10 truncated", int'(truncated), 0);
        check_cr_file("R10 cr reset");

        for (int k = 0; k < NREG; k++) load_gpr(k, vals[k]);

        // R8: all pass, vector both; R11 mid-walk pulse ignored
        run("all_pass", 5, 0, 1, 0, 1, 50, 0, 1, 0, 1'b1);
        // R6: inclusive fail at element 3
        run("incl_fail", 8, 0, 1, 2, 1, 10, 0, 1, 0, 1'b0);
        // R7: exclusive fail at element 3, entry 7 untouched
        run("excl_fail", 8, 0, 1, 4, 1, 10, 0, 1, 1, 1'b1);
        // R7: exclusive fail at element 0 truncates to zero
        run("excl_zero", 4, 3, 1, 0, 1, 10, 0, 1, 1, 1'b0);
        // R9: zero length
        run("len_zero", 0, 0, 1, 0, 1, 0, 2, 1, 0, 1'b0);
        // R2 scalar source, equal test
        run("scalar_src", 6, 12, 0, 0, 1, 100, 2, 1, 0, 1'b1);
        // R3 scalar destination, clear sense on greater, negative immediate
        run("scalar_dst", 6, 5, 1, 7, 0, -5, 1, 0, 0, 1'b0);
        // R2 R3 wrap; fail on last element keeps vl but flags truncation
        run("wrap_last", 5, 14, 1, 6, 1, 0, 2, 0, 0, 1'b1);
        // R5 selector code 3 behaves as equal, exclusive
        run("sel3_excl", 3, 9, 1, 3, 1, 0, 3, 1, 1, 1'b0);
        // R8 longest walk, scalar both
        run("long_scalar", 31, 0, 0, 1, 0, 6, 0, 1, 0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule